// File: doc/BRIEF.md
# Input Capture and Transition Counter Channel

This block watches one input pin for transitions of a selectable polarity and counts them. When the count reaches a programmed limit, it latches the value of one of two free-running timers and raises an interrupt request. In continuous operation the count then starts again from zero. In one-shot operation the channel goes quiet and reports itself as finished until software re-arms it.

Each capture event can also do two further things. It can pulse a set of link lines toward a contiguous, wrapping block of at most eight neighbouring channels. It can also ask a shared byte memory to increment one byte, which another channel can use as a flag. The increment port is a valid/ready stream. While `inc_valid` is high the block presents a byte address and expects the current byte on `inc_rdata` in the same cycle. It supplies the new value on `inc_wdata`, and the memory writes it on the cycle where `inc_ready` is also high. A low `inc_ready` is back-pressure: the request stays valid with a stable address, and events that arrive in the meantime are folded into the same write.

Configuration pins are assumed to be static while the channel is active.

Top module: `icap_channel`

## Requirements
- R1: `cfg_edge` selects which pin transitions qualify: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none.
- R2: On a capture event, `capture_value` loads `timer_a` when `cfg_timer_sel` is 0 or `timer_b` when it is 1. The timer value is the one present in the cycle before the third rising clock edge after the pin changes (two synchronizer stages plus one output register). `capture_value` holds between events.
- R3: `irq` goes high on each capture event and stays high until a cycle with `irq_ack` high. A new event in the same cycle as `irq_ack` keeps it high.
- R4: A capture event occurs on the Nth qualifying transition, where N is `cfg_max_count` and a value of 0 acts as 1. In continuous mode (`cfg_single`=0) counting restarts at zero after every event.
- R5: In single mode (`cfg_single`=1) the first event sets `done`. While `done` is high, transitions produce no capture, no interrupt, no link and no flag. A one-cycle `rearm` clears `done` and the count.
- R6: When `cfg_link_en` is 1, an event drives `link_out` high for exactly one cycle on bits `cfg_link_start` through `cfg_link_start`+K-1 modulo NUM_CH. K is `cfg_link_count` capped at 8. With `cfg_link_en` at 0, `link_out` stays zero.
- R7: When `cfg_flag_en` is 1, an event raises `inc_valid` on the following cycle with `inc_addr`=`cfg_flag_addr`. The block drives `inc_wdata` = `inc_rdata` + pending count modulo 256, so that 255 plus one writes 0.
- R8: While `inc_ready` is low, `inc_valid` stays high and further events add to the pending count, which saturates at 15. One handshake consumes the whole pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous input pin |
| timer_a | input | TIMER_W | First free-running timer |
| timer_b | input | TIMER_W | Second free-running timer |
| cfg_edge | input | 2 | Qualifying transition select |
| cfg_timer_sel | input | 1 | Timer chosen for capture |
| cfg_max_count | input | CNT_W | Transitions per event (0 acts as 1) |
| cfg_single | input | 1 | 1 = one-shot, 0 = continuous |
| rearm | input | 1 | Clears done and count |
| cfg_link_en | input | 1 | Enables link pulses |
| cfg_link_start | input | CH_W | First linked channel |
| cfg_link_count | input | 4 | Number of linked channels (capped at 8) |
| cfg_flag_en | input | 1 | Enables the byte increment |
| cfg_flag_addr | input | ADDR_W | Byte address to increment |
| irq_ack | input | 1 | Clears the interrupt request |
| capture_value | output | TIMER_W | Last captured timer value |
| irq | output | 1 | Interrupt request level |
| done | output | 1 | Single-mode finished |
| link_out | output | NUM_CH | One-cycle link pulses |
| inc_valid | output | 1 | Increment request valid |
| inc_ready | input | 1 | Memory accepts the write |
| inc_addr | output | ADDR_W | Byte address |
| inc_rdata | input | 8 | Current byte at inc_addr |
| inc_wdata | output | 8 | Incremented byte |

## Verification
The bench builds the channel with its defaults: 16-bit timers, an 8-bit transition count, 16 link lines and an 8-bit flag address. With 16 link lines, a start of 14 and a count of 4 makes the link range cross the top bit and wrap to 0. A count of 12 checks the cap of eight. The 8-bit byte path lets a preloaded 255 show the wrap to 0, and a held-off `inc_ready` shows several events merging into one write.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int LINK_MAX = 8;
  localparam int BYTE_W   = 8;
endpackage

// File: rtl/icap_edge_detect.sv
module icap_edge_detect #(
  parameter int SYNC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pin_in,
  input  icap_pkg::edge_sel_e    mode,
  output logic                   hit
);
  logic [SYNC:0] chain_q;
  logic          cur, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC-1:0], pin_in};
  end

  assign cur  = chain_q[SYNC-1];
  assign prev = chain_q[SYNC];

  always_comb begin
    unique case (mode)
      icap_pkg::EDGE_RISE: hit = cur & ~prev;
      icap_pkg::EDGE_FALL: hit = ~cur & prev;
      icap_pkg::EDGE_BOTH: hit = cur ^ prev;
      default:             hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/icap_trans_counter.sv
module icap_trans_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CNT_W-1:0] max_count,
  input  logic             single,
  input  logic             rearm,
  output logic             event_o,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   limit, next_cnt;
  logic             reached;

  always_comb begin
    limit    = (max_count == '0) ? (CNT_W+1)'(1) : {1'b0, max_count};
    next_cnt = {1'b0, cnt_q} + (CNT_W+1)'(1);
    reached  = (next_cnt == limit);
    event_o  = hit && !done && !rearm && reached;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (rearm) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (hit && !done) begin
      if (reached) begin
        cnt_q <= '0;
        if (single) done <= 1'b1;
      end else begin
        cnt_q <= next_cnt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/icap_link_gen.sv
module icap_link_gen #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              enable,
  input  logic [CH_W-1:0]   start,
  input  logic [3:0]        count,
  output logic [NUM_CH-1:0] link_q
);
  logic [3:0]        eff_count;
  logic [NUM_CH-1:0] in_range;

  assign eff_count = (count > 4'(icap_pkg::LINK_MAX)) ? 4'(icap_pkg::LINK_MAX) : count;

  for (genvar j = 0; j < NUM_CH; j++) begin : g_lane
    logic [CH_W-1:0] offset;
    assign offset      = CH_W'(j) - start;
    assign in_range[j] = ({{(32-CH_W){1'b0}}, offset} < {28'd0, eff_count});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               link_q <= '0;
    else if (fire && enable)  link_q <= in_range;
    else                      link_q <= '0;
  end
endmodule

// File: rtl/icap_flag_inc.sv
module icap_flag_inc #(
  parameter int ADDR_W = 8,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr_cfg,
  output logic              inc_valid,
  input  logic              inc_ready,
  output logic [ADDR_W-1:0] inc_addr,
  input  logic [7:0]        inc_rdata,
  output logic [7:0]        inc_wdata
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend_q, base;
  logic              take;

  assign inc_valid = (pend_q != '0);
  assign inc_addr  = addr_cfg;
  assign take      = inc_valid && inc_ready;
  assign inc_wdata = inc_rdata + 8'(pend_q);

  always_comb begin
    base = take ? '0 : pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   pend_q <= '0;
    else if (fire && enable && base != PEND_MAX)  pend_q <= base + 1'b1;
    else                                          pend_q <= base;
  end
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int TIMER_W = 16,
  parameter int CNT_W   = 8,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 8,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_in,
  input  logic [TIMER_W-1:0] timer_a,
  input  logic [TIMER_W-1:0] timer_b,
  input  logic [1:0]         cfg_edge,
  input  logic               cfg_timer_sel,
  input  logic [CNT_W-1:0]   cfg_max_count,
  input  logic               cfg_single,
  input  logic               rearm,
  input  logic               cfg_link_en,
  input  logic [CH_W-1:0]    cfg_link_start,
  input  logic [3:0]         cfg_link_count,
  input  logic               cfg_flag_en,
  input  logic [ADDR_W-1:0]  cfg_flag_addr,
  input  logic               irq_ack,
  output logic [TIMER_W-1:0] capture_value,
  output logic               irq,
  output logic               done,
  output logic [NUM_CH-1:0]  link_out,
  output logic               inc_valid,
  input  logic               inc_ready,
  output logic [ADDR_W-1:0]  inc_addr,
  input  logic [7:0]         inc_rdata,
  output logic [7:0]         inc_wdata
);
  logic hit, cap_event;
  icap_pkg::edge_sel_e mode;

  assign mode = icap_pkg::edge_sel_e'(cfg_edge);

  icap_edge_detect #(.SYNC(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode(mode), .hit(hit)
  );

  icap_trans_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .hit(hit), .max_count(cfg_max_count),
    .single(cfg_single), .rearm(rearm), .event_o(cap_event), .done(done)
  );

  icap_link_gen #(.NUM_CH(NUM_CH)) u_link (
    .clk(clk), .rst_n(rst_n), .fire(cap_event), .enable(cfg_link_en),
    .start(cfg_link_start), .count(cfg_link_count), .link_q(link_out)
  );

  icap_flag_inc #(.ADDR_W(ADDR_W), .PEND_W(4)) u_flag (
    .clk(clk), .rst_n(rst_n), .fire(cap_event), .enable(cfg_flag_en),
    .addr_cfg(cfg_flag_addr), .inc_valid(inc_valid), .inc_ready(inc_ready),
    .inc_addr(inc_addr), .inc_rdata(inc_rdata), .inc_wdata(inc_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capture_value <= '0;
      irq           <= 1'b0;
    end else begin
      if (cap_event) capture_value <= cfg_timer_sel ? timer_b : timer_a;
      if (cap_event)    irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_checker.sv
module icap_checker #(
  parameter int TIMER_W = 16,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hit,
  input logic               rearm,
  input logic               irq,
  input logic               done,
  input logic [TIMER_W-1:0] capture_value,
  input logic [NUM_CH-1:0]  link_out,
  input logic               inc_valid,
  input logic               inc_ready
);
  assert_link_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(link_out) <= icap_pkg::LINK_MAX);

  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit));

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rearm) |=> done);

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(capture_value));

  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_valid && !inc_ready) |=> inc_valid);
endmodule

bind icap_channel icap_checker #(
  .TIMER_W(TIMER_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
) u_icap_checker (
  .clk(clk), .rst_n(rst_n), .hit(hit), .rearm(rearm), .irq(irq), .done(done),
  .capture_value(capture_value), .link_out(link_out),
  .inc_valid(inc_valid), .inc_ready(inc_ready)
);

// File: tb/icap_channel_bench.sv
module icap_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic [15:0] timer_a = '0, timer_b = '0;
  logic [1:0]  cfg_edge = 2'b01;
  logic        cfg_timer_sel = 1'b0;
  logic [7:0]  cfg_max_count = 8'd1;
  logic        cfg_single = 1'b0, rearm = 1'b0;
  logic        cfg_link_en = 1'b0;
  logic [3:0]  cfg_link_start = '0, cfg_link_count = '0;
  logic        cfg_flag_en = 1'b0;
  logic [7:0]  cfg_flag_addr = 8'd5;
  logic        irq_ack = 1'b0;
  logic [15:0] capture_value;
  logic        irq, done, inc_valid;
  logic        inc_ready = 1'b1;
  logic [15:0] link_out;
  logic [7:0]  inc_addr, inc_rdata, inc_wdata;

  logic [7:0]  mem [256];
  logic        pre_en = 1'b0;
  logic [7:0]  pre_addr = '0, pre_data = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  icap_channel u_icap_channel (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_a(timer_a), .timer_b(timer_b),
    .cfg_edge(cfg_edge), .cfg_timer_sel(cfg_timer_sel), .cfg_max_count(cfg_max_count),
    .cfg_single(cfg_single), .rearm(rearm), .cfg_link_en(cfg_link_en),
    .cfg_link_start(cfg_link_start), .cfg_link_count(cfg_link_count),
    .cfg_flag_en(cfg_flag_en), .cfg_flag_addr(cfg_flag_addr), .irq_ack(irq_ack),
    .capture_value(capture_value), .irq(irq), .done(done), .link_out(link_out),
    .inc_valid(inc_valid), .inc_ready(inc_ready), .inc_addr(inc_addr),
    .inc_rdata(inc_rdata), .inc_wdata(inc_wdata)
  );

  assign inc_rdata = mem[inc_addr];

  always @(posedge clk) begin
    if (pre_en) mem[pre_addr] <= pre_data;
    else if (inc_valid && inc_ready) mem[inc_addr] <= inc_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pre_en = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk); pre_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3 reset irq", irq, 0);
    chk("R5 reset done", done, 0);
    chk("R6 reset link", link_out, 0);
    chk("R7 reset valid", inc_valid, 0);
    chk("R2 reset capture", capture_value, 0);
  endtask

  task automatic t_edges();
    cfg_edge = 2'b01; timer_a = 16'd100;
    drive_pin(1);
    chk("R1 rising captured", capture_value, 16'd100);
    chk("R3 irq set", irq, 1);
    @(negedge clk); chk("R3 irq held", irq, 1);
    ack(); chk("R3 irq acked", irq, 0);
    timer_a = 16'd200;
    drive_pin(0);
    chk("R1 falling ignored in rise mode", irq, 0);
    chk("R1 capture unchanged", capture_value, 16'd100);
    cfg_edge = 2'b10;
    drive_pin(1); chk("R1 rise ignored in fall mode", irq, 0);
    drive_pin(0); chk("R1 fall captured", capture_value, 16'd200);
    ack();
    cfg_edge = 2'b11; timer_a = 16'd300;
    drive_pin(1); chk("R1 both rise", capture_value, 16'd300);
    timer_a = 16'd301;
    drive_pin(0); chk("R1 both fall", capture_value, 16'd301);
    ack();
    cfg_edge = 2'b00; timer_a = 16'd400;
    drive_pin(1); drive_pin(0);
    chk("R1 none mode", capture_value, 16'd301);
    chk("R1 none irq", irq, 0);
  endtask

  task automatic t_count();
    cfg_edge = 2'b11; cfg_max_count = 8'd3; cfg_timer_sel = 1'b1; timer_b = 16'hBEEF;
    drive_pin(1); chk("R4 edge 1 no event", irq, 0);
    drive_pin(0); chk("R4 edge 2 no event", irq, 0);
    drive_pin(1); chk("R4 edge 3 event", irq, 1);
    chk("R2 timer_b selected", capture_value, 16'hBEEF);
    ack();
    timer_b = 16'h1234;
    drive_pin(0); drive_pin(1);
    chk("R4 restart needs full count", irq, 0);
    drive_pin(0); chk("R4 second event", capture_value, 16'h1234);
    ack();
    cfg_max_count = 8'd0; cfg_timer_sel = 1'b0; timer_a = 16'd7;
    drive_pin(1); chk("R4 zero acts as one", capture_value, 16'd7);
    // R3: event and ack in the same cycle keeps irq high
    timer_a = 16'd8;
    @(negedge clk); pin_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R3 set wins over ack", irq, 1);
    ack();
  endtask

  task automatic t_single();
    cfg_single = 1'b1; cfg_max_count = 8'd2; cfg_edge = 2'b11; timer_a = 16'd50;
    drive_pin(1); chk("R5 not yet done", done, 0);
    drive_pin(0); chk("R5 done set", done, 1);
    chk("R5 captured", capture_value, 16'd50);
    ack();
    timer_a = 16'd60;
    drive_pin(1); drive_pin(0);
    chk("R5 edges ignored while done", capture_value, 16'd50);
    chk("R5 no irq while done", irq, 0);
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    chk("R5 rearm clears done", done, 0);
    drive_pin(1); drive_pin(0);
    chk("R5 capture after rearm", capture_value, 16'd60);
    ack();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    cfg_single = 1'b0;
  endtask

  task automatic t_links();
    cfg_edge = 2'b11; cfg_max_count = 8'd1; cfg_link_en = 1'b1;
    cfg_link_start = 4'd14; cfg_link_count = 4'd4;
    drive_pin(1); chk("R6 wrapping range", link_out, 16'hC003);
    @(negedge clk); chk("R6 single cycle", link_out, 0);
    cfg_link_start = 4'd3; cfg_link_count = 4'd12;
    drive_pin(0); chk("R6 capped at eight", link_out, 16'h07F8);
    cfg_link_en = 1'b0;
    drive_pin(1); chk("R6 disabled", link_out, 0);
    ack();
  endtask

  task automatic t_flag();
    cfg_flag_en = 1'b1; cfg_flag_addr = 8'd5; inc_ready = 1'b1;
    poke(8'd5, 8'hFF);
    drive_pin(0);
    chk("R7 valid raised", inc_valid, 1);
    chk("R7 address", inc_addr, 8'd5);
    @(negedge clk);
    chk("R7 wrap to zero", mem[5], 8'h00);
    chk("R7 valid dropped", inc_valid, 0);
    ack();
  endtask

  task automatic t_backpressure();
    cfg_flag_addr = 8'd9; poke(8'd9, 8'd10);
    inc_ready = 1'b0;
    drive_pin(1); drive_pin(0); drive_pin(1);
    chk("R8 valid held", inc_valid, 1);
    chk("R8 memory untouched", mem[9], 8'd10);
    @(negedge clk); inc_ready = 1'b1;
    @(negedge clk);
    chk("R8 merged increment", mem[9], 8'd13);
    chk("R8 valid cleared", inc_valid, 0);
    ack();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'd0;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_count();
    t_single();
    t_links();
    t_flag();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule